// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Start-Up Delay

This block is a down-counting watchdog driven by an instruction-cycle enable. When reset is released the counter loads its all-ones value and starts counting at once. The first time it runs past zero it raises a warning flag. If software does not restart it before the next pass past zero, a second flag rises and the block issues a one-cycle internal reset request. That request also puts the block back into its own reset state.

The same counter sets the oscillator settling time. After reset, after its own reset request, or after a wake-up from the power-off state, the software-start ready output stays low until the counter has fallen to a programmable level. A power-off request freezes the block until a wake-up pulse arrives.

All commands (`kick`, `wake`, `pwr_off`) are active-high and are sampled on every clock edge. Counting happens only on edges where `tick` is high.

Top module: `wdt_two_stage`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `uflow_flag`, `bark_flag`, `sys_rst` and `sw_ready` are 0, and the counter holds 2^WIDTH-1.
- R2: The counter falls by one on each clock edge where `tick` is high. On edges where `tick` is low it holds. From a reload, exactly 2^WIDTH ticks bring it past zero.
- R3: A tick with the counter at zero and `uflow_flag` at 0 sets `uflow_flag` to 1 and reloads the counter with 2^WIDTH-1.
- R4: A tick with the counter at zero and `uflow_flag` at 1 sets `bark_flag` and `sys_rst` to 1. On the next tick edge `sys_rst`, both flags and `sw_ready` return to 0, the counter reloads, and the block wakes if it was asleep. `sys_rst` is therefore high for exactly one enabled cycle.
- R5: A `kick` clears both flags and reloads the counter without changing `sw_ready`. Kicks spaced by fewer than 2^WIDTH ticks keep `uflow_flag` at 0.
- R6: `sw_ready` rises on the tick that brings the counter to STAB_LEVEL, counted from the reload after reset, after a reset request, or after a wake-up.
- R7: `pwr_off` drives `sw_ready` to 0 and puts the block to sleep. While asleep, `tick`, `kick` and `pwr_off` have no effect, and the counter and flags hold.
- R8: `wake` while asleep reloads the counter, clears both flags and resumes counting with `sw_ready` at 0. `wake` while awake has no effect.
- R9: While `sys_rst` is high, every command input is ignored. If commands arrive together, `wake` (when asleep) wins over `pwr_off`, and `pwr_off` wins over `kick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Instruction-cycle enable, counts when high |
| kick | input | 1 | Restart command pulse |
| wake | input | 1 | Wake-up pulse from the power-off state |
| pwr_off | input | 1 | Power-off request pulse |
| uflow_flag | output | 1 | First-underflow flag |
| bark_flag | output | 1 | Second-underflow flag |
| sys_rst | output | 1 | Internal reset request, one enabled cycle |
| sw_ready | output | 1 | Settling window over, software may start |

## Verification
The bench builds the block with WIDTH=6 and STAB_LEVEL=56. A counter period is then 64 ticks and the settling window is 7 ticks. With these values both underflow stages, the reset request and its self-clear happen many times within a short run, including during a long mixed-stimulus phase with gapped ticks. The same logic at the default 14-bit width differs only in the counter's length.

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int WIDTH      = 14,
  parameter int STAB_LEVEL = 'h3E00
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic kick,
  input  logic wake,
  input  logic pwr_off,
  output logic uflow_flag,
  output logic bark_flag,
  output logic sys_rst,
  output logic sw_ready
);
  localparam logic [WIDTH-1:0] TOP  = '1;
  localparam logic [WIDTH-1:0] STAB = WIDTH'(STAB_LEVEL);

  logic [WIDTH-1:0] cnt;
  logic             asleep;

  wire              at_zero = (cnt == '0);
  wire [WIDTH-1:0]  dec     = cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= TOP;
      uflow_flag <= 1'b0;
      bark_flag  <= 1'b0;
      sys_rst    <= 1'b0;
      sw_ready   <= 1'b0;
      asleep     <= 1'b0;
    end else if (sys_rst) begin
      if (tick) begin
        cnt        <= TOP;
        uflow_flag <= 1'b0;
        bark_flag  <= 1'b0;
        sys_rst    <= 1'b0;
        sw_ready   <= 1'b0;
        asleep     <= 1'b0;
      end
    end else if (asleep) begin
      if (wake) begin
        asleep     <= 1'b0;
        cnt        <= TOP;
        uflow_flag <= 1'b0;
        bark_flag  <= 1'b0;
      end
    end else if (pwr_off) begin
      asleep   <= 1'b1;
      sw_ready <= 1'b0;
    end else if (kick) begin
      cnt        <= TOP;
      uflow_flag <= 1'b0;
      bark_flag  <= 1'b0;
    end else if (tick) begin
      if (at_zero) begin
        cnt <= TOP;
        if (uflow_flag) begin
          bark_flag <= 1'b1;
          sys_rst   <= 1'b1;
        end else begin
          uflow_flag <= 1'b1;
        end
      end else begin
        cnt <= dec;
        if (dec == STAB) sw_ready <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
  parameter int WIDTH      = 14,
  parameter int STAB_LEVEL = 'h3E00
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             kick,
  input logic             wake,
  input logic             pwr_off,
  input logic             uflow_flag,
  input logic             bark_flag,
  input logic             sys_rst,
  input logic             sw_ready,
  input logic [WIDTH-1:0] cnt,
  input logic             asleep
);
  localparam logic [WIDTH-1:0] TOP  = '1;
  localparam logic [WIDTH-1:0] STAB = WIDTH'(STAB_LEVEL);

  // R4
  one_shot_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst && tick |=> !sys_rst && !uflow_flag && !bark_flag);

  // R4
  bark_after_uflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bark_flag |-> uflow_flag);

  // R3
  wrap_on_uflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uflow_flag) |-> cnt == TOP);

  // R5
  kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick && !pwr_off && !sys_rst && !asleep |=> !uflow_flag && !bark_flag);

  // R6
  ready_at_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_ready) |-> cnt == STAB);

  // R7
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep && !wake |=> $stable(cnt) && $stable(uflow_flag) && !sw_ready);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !kick && !wake && !pwr_off |=> $stable(cnt));
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.WIDTH(WIDTH), .STAB_LEVEL(STAB_LEVEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .wake(wake),
  .pwr_off(pwr_off), .uflow_flag(uflow_flag), .bark_flag(bark_flag),
  .sys_rst(sys_rst), .sw_ready(sw_ready), .cnt(cnt), .asleep(asleep)
);

// File: tb/tb_wdt_two_stage.sv
module tb_wdt_two_stage;
  localparam int W    = 6;
  localparam int STAB = 56;
  localparam int TOPV = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, kick = 0, wake = 0, pwr_off = 0;
  logic uflow_flag, bark_flag, sys_rst, sw_ready;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdt_two_stage #(.WIDTH(W), .STAB_LEVEL(STAB)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .wake(wake),
    .pwr_off(pwr_off), .uflow_flag(uflow_flag), .bark_flag(bark_flag),
    .sys_rst(sys_rst), .sw_ready(sw_ready));

  // behavioural reference
  int m_cnt, m_f1, m_f2, m_rst, m_rdy, m_sl;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = TOPV; m_f1 = 0; m_f2 = 0; m_rst = 0; m_rdy = 0; m_sl = 0;
    end else if (m_rst != 0) begin
      if (tick) begin m_cnt = TOPV; m_f1 = 0; m_f2 = 0; m_rst = 0; m_rdy = 0; m_sl = 0; end
    end else if (m_sl != 0) begin
      if (wake) begin m_sl = 0; m_cnt = TOPV; m_f1 = 0; m_f2 = 0; end
    end else if (pwr_off) begin
      m_sl = 1; m_rdy = 0;
    end else if (kick) begin
      m_cnt = TOPV; m_f1 = 0; m_f2 = 0;
    end else if (tick) begin
      if (m_cnt == 0) begin
        m_cnt = TOPV;
        if (m_f1 != 0) begin m_f2 = 1; m_rst = 1; end else m_f1 = 1;
      end else begin
        m_cnt = m_cnt - 1;
        if (m_cnt == STAB) m_rdy = 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 uflow_flag vs model", int'(uflow_flag), m_f1);
      chk("R4 bark_flag vs model", int'(bark_flag), m_f2);
      chk("R4 sys_rst vs model", int'(sys_rst), m_rst);
      chk("R6 sw_ready vs model", int'(sw_ready), m_rdy);
    end
  end

  task automatic cyc(input logic t, input logic k, input logic w, input logic p);
    tick = t; kick = k; wake = w; pwr_off = p;
    @(negedge clk);
    tick = 0; kick = 0; wake = 0; pwr_off = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 uflow in reset", int'(uflow_flag), 0);
    chk("R1 sys_rst in reset", int'(sys_rst), 0);
    chk("R1 ready in reset", int'(sw_ready), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 bark after release", int'(bark_flag), 0);

    // R6 settling window: 7 ticks
    ticks(6);
    chk("R6 ready one tick early", int'(sw_ready), 0);
    ticks(1);
    chk("R6 ready at level", int'(sw_ready), 1);

    // R2 gapped ticks: 57 more to first underflow
    for (int i = 0; i < 56; i++) begin cyc(1, 0, 0, 0); cyc(0, 0, 0, 0); end
    chk("R2 no uflow one tick early", int'(uflow_flag), 0);
    cyc(1, 0, 0, 0);
    chk("R3 first underflow", int'(uflow_flag), 1);

    ticks(63);
    chk("R4 no bark one tick early", int'(bark_flag), 0);
    ticks(1);
    chk("R4 bark set", int'(bark_flag), 1);
    chk("R4 reset request", int'(sys_rst), 1);
    cyc(0, 1, 0, 1);
    chk("R9 kick ignored during request", int'(uflow_flag), 1);
    chk("R9 request held without tick", int'(sys_rst), 1);
    cyc(1, 0, 0, 0);
    chk("R4 request ends", int'(sys_rst), 0);
    chk("R4 flags cleared", int'(uflow_flag), 0);
    chk("R4 ready cleared", int'(sw_ready), 0);

    // R5 periodic kicks
    for (int i = 0; i < 5; i++) begin ticks(60); cyc(0, 1, 0, 0); end
    chk("R5 no uflow with kicks", int'(uflow_flag), 0);
    chk("R5 ready kept by kick", int'(sw_ready), 1);

    // R7 sleep
    ticks(64);
    chk("R3 uflow before sleep", int'(uflow_flag), 1);
    cyc(0, 0, 0, 1);
    chk("R7 ready dropped", int'(sw_ready), 0);
    ticks(200);
    chk("R7 no bark while asleep", int'(bark_flag), 0);
    cyc(1, 1, 0, 0);
    chk("R7 kick ignored asleep", int'(uflow_flag), 1);

    // R8 / R9 wake beats power-off
    cyc(0, 0, 1, 1);
    chk("R8 flags cleared by wake", int'(uflow_flag), 0);
    ticks(6);
    chk("R8 ready low after wake", int'(sw_ready), 0);
    ticks(1);
    chk("R8 ready after window", int'(sw_ready), 1);
    cyc(0, 0, 1, 0);
    chk("R8 wake ignored when awake", int'(sw_ready), 1);
    ticks(57);
    chk("R3 uflow again", int'(uflow_flag), 1);
    cyc(0, 1, 0, 1);
    chk("R9 power-off beats kick", int'(uflow_flag), 1);
    chk("R9 asleep after tie", int'(sw_ready), 0);
    cyc(0, 0, 1, 0);

    // mixed stimulus against model
    for (int i = 0; i < 6000; i++) begin
      int r = int'($urandom_range(0, 999));
      cyc(r < 700, r >= 990, (r % 37) == 0, r == 5 || r == 701);
    end

    // R1 reset mid-run
    rst_n = 0;
    @(negedge clk);
    chk("R1 reset mid-run ready", int'(sw_ready), 0);
    chk("R1 reset mid-run uflow", int'(uflow_flag), 0);
    finish_run();
  end
endmodule